// File: doc/BRIEF.md
# Command Ring Control Register Unit

This block is the register front end for a command ring held in main memory. Software reaches it over a 16-bit register bus. It sets up the ring window with a base and an end address, and it programs a fill distance, two fill thresholds and a stop address. Each of these is a 32-bit value written as two halfwords. The CPU-side write combiner signals each 32-byte burst it pushes into the ring. The unit then moves the producer pointer around the ring and adds to the fill distance.

A fetch engine outside this block reads `fetch_ok_o` and `rd_ptr_o`. It pulses `fetch_pop_i` each time it consumes one 32-byte line. The unit then moves the consumer pointer and subtracts from the distance. A producer step and a consumer step in the same cycle cancel in the distance.

The unit also keeps sticky fill flags and a stop-address hit flag. Together with per-source enables, these drive one level interrupt.

Top module: `cmdq_ctrl_regs`

## Requirements
- R1: After reset, the state register reads 0x000C. Control, token, the eight wide registers and `irq_o` are all zero.
- R2: A write to the low halfword of a wide register replaces only bits 15:0. A write to the high halfword replaces only bits 31:16.
- R3: Low-half writes to base, end, producer pointer, consumer pointer, stop address and distance clear bits 4:0. Low-half writes to the two thresholds are stored as written.
- R4: A read returns the register at halfword index addr[11:1], and indices 0x20 and above read zero. The map is:
  - 0: state
  - 1: control
  - 2: clear (reads zero)
  - 3: token
  - 4 to 15: zero
  - 16/17: base lo/hi
  - 18/19: end lo/hi
  - 20/21: high threshold lo/hi
  - 22/23: low threshold lo/hi
  - 24/25: distance lo/hi
  - 26/27: producer pointer lo/hi
  - 28/29: consumer pointer lo/hi
  - 30/31: stop address lo/hi

  Control bits are: 0 fetch enable, 1 stop enable, 2 overflow interrupt enable, 3 underflow interrupt enable, 4 burst link enable, 5 stop interrupt enable.
- R5: Writes to the state register (index 0) have no effect.
- R6: When link is enabled, a burst pulse does two things. The producer pointer becomes base if it equals end, and otherwise it advances by 32. The distance also grows by 32. When link is disabled, a burst changes nothing.
- R7: `fetch_ok_o` is high exactly when three conditions hold: fetch is enabled, the consumer pointer differs from the producer pointer, and the unit is not stopped. The unit is stopped when stop is enabled and the consumer pointer equals the stop address. A pop while `fetch_ok_o` is high advances the consumer pointer, with the same wrap rule as R6, and subtracts 32 from the distance. Any other pop is ignored.
- R8: An accepted burst and an accepted pop in the same cycle leave the distance unchanged.
- R9: State bit 0 (overflow) sets on the edge after distance exceeds the high threshold. State bit 1 (underflow) sets on the edge after distance is below the low threshold. Both flags hold until cleared. If the condition still holds in the cycle of a clear, the set wins.
- R10: Writing the clear register with bit 0 set drops the overflow flag, and with bit 1 set drops the underflow flag.
- R11: While stop is enabled, state bit 4 sets on the edge after the consumer pointer equals the stop address, and then holds. While stop is disabled, bit 4 drops on the next edge.
- R12: State bit 2 is high whenever the consumer pointer equals the producer pointer. State bit 3 is the registered inverse of `decode_busy_i`.
- R13: `irq_o` is the OR of three terms: stop flag AND stop interrupt enable, overflow AND its enable, and underflow AND its enable.
- R14: A bus write to either half of a wide register takes priority over a burst or pop update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 12 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on address |
| burst_i | input | 1 | One 32-byte producer burst |
| fetch_pop_i | input | 1 | Fetch engine consumed one 32-byte line |
| decode_busy_i | input | 1 | Command decoder busy |
| fetch_ok_o | output | 1 | Fetch engine may consume a line |
| rd_ptr_o | output | 32 | Consumer pointer |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is the cycle where the producer is on the end address and wraps to base, while the fetch side consumes a line at the same time. In that one edge, three registers update together and the distance must net to zero. The stimulus drives the pointers to that exact position by programming a three-line ring and counting bursts and pops. It then raises both pulses in one cycle and reads back all three registers. A second hard case is a bus write to the distance in the same cycle as an accepted burst, which is driven by a task that asserts both strobes together.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ADDR_W = 12;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int N_WIDE = 8;

  typedef enum logic [2:0] {
    W_BASE, W_END, W_HIWM, W_LOWM, W_DIST, W_WPTR, W_RPTR, W_BRK
  } wide_e;

  localparam logic [IDX_W-1:0] IDX_STAT  = 11'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 11'd1;
  localparam logic [IDX_W-1:0] IDX_CLR   = 11'd2;
  localparam logic [IDX_W-1:0] IDX_TOKEN = 11'd3;
  localparam logic [IDX_W-1:0] IDX_WIDE0 = 11'd16;
  localparam logic [IDX_W-1:0] IDX_LIMIT = 11'd32;

  typedef struct packed {
    logic bp_ie;
    logic link_en;
    logic udf_ie;
    logic ovf_ie;
    logic bp_en;
    logic rd_en;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] ring_next(input logic [WORD_W-1:0] ptr,
                                                  input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] last,
                                                  input logic [WORD_W-1:0] step);
    return (ptr == last) ? base : ptr + step;
  endfunction
endpackage

// File: rtl/cmdq_split_reg.sv
module cmdq_split_reg #(
  parameter int H = 16,
  parameter logic [H-1:0] LO_MASK = '1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_lo_i,
  input  logic           wr_hi_i,
  input  logic [H-1:0]   wdata_i,
  input  logic           hw_ld_i,
  input  logic [2*H-1:0] hw_val_i,
  output logic [2*H-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      // bus access wins over hardware update
      if (wr_lo_i) q_o[H-1:0]   <= wdata_i & LO_MASK;
      if (wr_hi_i) q_o[2*H-1:H] <= wdata_i;
    end else if (hw_ld_i) begin
      q_o <= hw_val_i;
    end
  end
endmodule

// File: rtl/cmdq_advance.sv
module cmdq_advance
  import cmdq_pkg::*;
#(
  parameter int LINE_BYTES = 32
) (
  input  logic              burst_i,
  input  logic              pop_i,
  input  ctrl_t             ctrl_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] end_i,
  input  logic [WORD_W-1:0] wptr_i,
  input  logic [WORD_W-1:0] rptr_i,
  input  logic [WORD_W-1:0] brk_i,
  input  logic [WORD_W-1:0] dist_i,
  output logic              fetch_ok_o,
  output logic              wptr_ld_o,
  output logic [WORD_W-1:0] wptr_nxt_o,
  output logic              rptr_ld_o,
  output logic [WORD_W-1:0] rptr_nxt_o,
  output logic              dist_ld_o,
  output logic [WORD_W-1:0] dist_nxt_o
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(LINE_BYTES);

  logic at_brk, push_go, pop_go;

  assign at_brk     = ctrl_i.bp_en && (rptr_i == brk_i);
  assign fetch_ok_o = ctrl_i.rd_en && !at_brk && (rptr_i != wptr_i);
  assign push_go    = burst_i && ctrl_i.link_en;
  assign pop_go     = pop_i && fetch_ok_o;

  assign wptr_ld_o  = push_go;
  assign wptr_nxt_o = ring_next(wptr_i, base_i, end_i, STEP);
  assign rptr_ld_o  = pop_go;
  assign rptr_nxt_o = ring_next(rptr_i, base_i, end_i, STEP);
  // simultaneous push and pop net to zero: no load
  assign dist_ld_o  = push_go ^ pop_go;
  assign dist_nxt_o = push_go ? dist_i + STEP : dist_i - STEP;
endmodule

// File: rtl/cmdq_status.sv
module cmdq_status
  import cmdq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] dist_i,
  input  logic [WORD_W-1:0] hiwm_i,
  input  logic [WORD_W-1:0] lowm_i,
  input  logic [WORD_W-1:0] rptr_i,
  input  logic [WORD_W-1:0] brk_i,
  input  logic              bp_en_i,
  input  logic              clr_ovf_i,
  input  logic              clr_udf_i,
  input  logic              busy_i,
  output logic              ovf_o,
  output logic              udf_o,
  output logic              bp_hit_o,
  output logic              cmd_idle_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o      <= 1'b0;
      udf_o      <= 1'b0;
      bp_hit_o   <= 1'b0;
      cmd_idle_o <= 1'b1;
    end else begin
      ovf_o      <= (ovf_o && !clr_ovf_i) || (dist_i > hiwm_i);
      udf_o      <= (udf_o && !clr_udf_i) || (dist_i < lowm_i);
      bp_hit_o   <= bp_en_i && (bp_hit_o || (rptr_i == brk_i));
      cmd_idle_o <= !busy_i;
    end
  end
endmodule

// File: rtl/cmdq_ctrl_regs.sv
module cmdq_ctrl_regs
  import cmdq_pkg::*;
#(
  parameter int LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [HALF_W-1:0] reg_wdata_i,
  output logic [HALF_W-1:0] reg_rdata_o,
  input  logic              burst_i,
  input  logic              fetch_pop_i,
  input  logic              decode_busy_i,
  output logic              fetch_ok_o,
  output logic [WORD_W-1:0] rd_ptr_o,
  output logic              irq_o
);
  localparam logic [HALF_W-1:0] ALIGN_MASK = ~HALF_W'(LINE_BYTES - 1);

  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  rel;
  logic              unused_addr_lsb;
  ctrl_t             ctrl_q;
  logic [HALF_W-1:0] token_q;
  logic [WORD_W-1:0] wide_q [N_WIDE];
  logic              hw_ld  [N_WIDE];
  logic [WORD_W-1:0] hw_val [N_WIDE];

  logic [WORD_W-1:0] base_q, end_q, hiwm_q, lowm_q, dist_q, wp_q, rp_q, bp_q;
  logic wp_ld, rp_ld, dist_ld;
  logic [WORD_W-1:0] wp_nxt, rp_nxt, dist_nxt;
  logic ovf_q, udf_q, bp_hit_q, cmd_idle_q, rd_idle;
  logic clr_ovf, clr_udf;

  assign idx             = reg_addr_i[ADDR_W-1:1];
  assign rel             = idx - IDX_WIDE0;
  assign unused_addr_lsb = reg_addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      token_q <= '0;
    end else if (reg_we_i) begin
      if (idx == IDX_CTRL)  ctrl_q  <= ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);
      if (idx == IDX_TOKEN) token_q <= reg_wdata_i;
    end
  end

  assign clr_ovf = reg_we_i && (idx == IDX_CLR) && reg_wdata_i[0];
  assign clr_udf = reg_we_i && (idx == IDX_CLR) && reg_wdata_i[1];

  for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
    localparam logic [IDX_W-1:0] LO_IDX = IDX_WIDE0 + IDX_W'(2 * k);
    localparam logic [HALF_W-1:0] MSK =
      (k == int'(W_HIWM) || k == int'(W_LOWM)) ? '1 : ALIGN_MASK;
    cmdq_split_reg #(.H(HALF_W), .LO_MASK(MSK)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_lo_i  (reg_we_i && (idx == LO_IDX)),
      .wr_hi_i  (reg_we_i && (idx == LO_IDX + 11'd1)),
      .wdata_i  (reg_wdata_i),
      .hw_ld_i  (hw_ld[k]),
      .hw_val_i (hw_val[k]),
      .q_o      (wide_q[k])
    );
  end

  assign base_q = wide_q[W_BASE];
  assign end_q  = wide_q[W_END];
  assign hiwm_q = wide_q[W_HIWM];
  assign lowm_q = wide_q[W_LOWM];
  assign dist_q = wide_q[W_DIST];
  assign wp_q   = wide_q[W_WPTR];
  assign rp_q   = wide_q[W_RPTR];
  assign bp_q   = wide_q[W_BRK];

  cmdq_advance #(.LINE_BYTES(LINE_BYTES)) u_adv (
    .burst_i    (burst_i),
    .pop_i      (fetch_pop_i),
    .ctrl_i     (ctrl_q),
    .base_i     (base_q),
    .end_i      (end_q),
    .wptr_i     (wp_q),
    .rptr_i     (rp_q),
    .brk_i      (bp_q),
    .dist_i     (dist_q),
    .fetch_ok_o (fetch_ok_o),
    .wptr_ld_o  (wp_ld),
    .wptr_nxt_o (wp_nxt),
    .rptr_ld_o  (rp_ld),
    .rptr_nxt_o (rp_nxt),
    .dist_ld_o  (dist_ld),
    .dist_nxt_o (dist_nxt)
  );

  always_comb begin
    for (int k = 0; k < N_WIDE; k++) begin
      hw_ld[k]  = 1'b0;
      hw_val[k] = '0;
    end
    hw_ld[W_WPTR]  = wp_ld;
    hw_val[W_WPTR] = wp_nxt;
    hw_ld[W_RPTR]  = rp_ld;
    hw_val[W_RPTR] = rp_nxt;
    hw_ld[W_DIST]  = dist_ld;
    hw_val[W_DIST] = dist_nxt;
  end

  cmdq_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dist_i     (dist_q),
    .hiwm_i     (hiwm_q),
    .lowm_i     (lowm_q),
    .rptr_i     (rp_q),
    .brk_i      (bp_q),
    .bp_en_i    (ctrl_q.bp_en),
    .clr_ovf_i  (clr_ovf),
    .clr_udf_i  (clr_udf),
    .busy_i     (decode_busy_i),
    .ovf_o      (ovf_q),
    .udf_o      (udf_q),
    .bp_hit_o   (bp_hit_q),
    .cmd_idle_o (cmd_idle_q)
  );

  assign rd_idle = (rp_q == wp_q);

  always_comb begin
    reg_rdata_o = '0;
    if (idx >= IDX_LIMIT) begin
      reg_rdata_o = '0;
    end else if (idx >= IDX_WIDE0) begin
      reg_rdata_o = rel[0] ? wide_q[rel[3:1]][WORD_W-1:HALF_W]
                           : wide_q[rel[3:1]][HALF_W-1:0];
    end else begin
      case (idx)
        IDX_STAT:  reg_rdata_o = {11'd0, bp_hit_q, cmd_idle_q, rd_idle, udf_q, ovf_q};
        IDX_CTRL:  reg_rdata_o = HALF_W'(ctrl_q);
        IDX_TOKEN: reg_rdata_o = token_q;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  assign rd_ptr_o = rp_q;
  assign irq_o    = (bp_hit_q && ctrl_q.bp_ie) || (ovf_q && ctrl_q.ovf_ie) ||
                    (udf_q && ctrl_q.udf_ie);
endmodule

// File: rtl/cmdq_ctrl_regs_chk.sv
module cmdq_ctrl_regs_chk
  import cmdq_pkg::*;
#(
  parameter int LINE_BYTES = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [HALF_W-1:0] reg_wdata_i,
  input logic              burst_i,
  input logic              fetch_pop_i,
  input logic              fetch_ok_o,
  input logic              irq_o,
  input logic [5:0]        ctrl_bits,
  input logic [WORD_W-1:0] base_q,
  input logic [WORD_W-1:0] end_q,
  input logic [WORD_W-1:0] dist_q,
  input logic [WORD_W-1:0] wp_q,
  input logic [WORD_W-1:0] rp_q,
  input logic [WORD_W-1:0] bp_q,
  input logic              ovf_q,
  input logic              bp_hit_q
);
  localparam logic [WORD_W-1:0] LMASK = WORD_W'(LINE_BYTES - 1);
  localparam logic [IDX_W-1:0] I_DIST = IDX_WIDE0 + 11'd8;
  localparam logic [IDX_W-1:0] I_WP   = IDX_WIDE0 + 11'd10;
  localparam logic [IDX_W-1:0] I_RP   = IDX_WIDE0 + 11'd12;

  logic [IDX_W-1:0] hidx;
  logic dist_touch, wp_touch, rp_touch, clr_ovf_wr, link, bp_en;
  assign hidx       = reg_addr_i[ADDR_W-1:1];
  assign dist_touch = reg_we_i && (hidx == I_DIST || hidx == I_DIST + 11'd1);
  assign wp_touch   = reg_we_i && (hidx == I_WP   || hidx == I_WP + 11'd1);
  assign rp_touch   = reg_we_i && (hidx == I_RP   || hidx == I_RP + 11'd1);
  assign clr_ovf_wr = reg_we_i && (hidx == IDX_CLR) && reg_wdata_i[0];
  assign link       = ctrl_bits[4];
  assign bp_en      = ctrl_bits[1];

  a_r6_burst_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && link && !wp_touch && (wp_q == end_q) |=> wp_q == $past(base_q));

  a_r6_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && link && !wp_touch && (wp_q != end_q)
      |=> wp_q == $past(wp_q) + WORD_W'(LINE_BYTES));

  a_r3_ptr_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wp_q | rp_q | bp_q | base_q | end_q | dist_q) & LMASK) == '0);

  a_r8_net_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && link && fetch_pop_i && fetch_ok_o && !dist_touch |=> $stable(dist_q));

  a_r7_pop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_pop_i && !fetch_ok_o && !rp_touch |=> $stable(rp_q));

  a_r7_stop_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_en && (rp_q == bp_q) |-> !fetch_ok_o);

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !clr_ovf_wr |=> ovf_q);

  a_r11_stop_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bp_en |=> !bp_hit_q);

  a_r13_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_bits[5] && !ctrl_bits[3] && !ctrl_bits[2] |-> !irq_o);
endmodule

bind cmdq_ctrl_regs cmdq_ctrl_regs_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .burst_i     (burst_i),
  .fetch_pop_i (fetch_pop_i),
  .fetch_ok_o  (fetch_ok_o),
  .irq_o       (irq_o),
  .ctrl_bits   (ctrl_q),
  .base_q      (base_q),
  .end_q       (end_q),
  .dist_q      (dist_q),
  .wp_q        (wp_q),
  .rp_q        (rp_q),
  .bp_q        (bp_q),
  .ovf_q       (ovf_q),
  .bp_hit_q    (bp_hit_q)
);

// File: tb/sim_cmdq_ctrl_regs.sv
`timescale 1ns/1ps
module sim_cmdq_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        burst = 1'b0, pop = 1'b0, busy = 1'b0;
  logic        fetch_ok, irq;
  logic [31:0] rd_ptr;

  always #10 clk = ~clk;

  cmdq_ctrl_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .burst_i(burst),
    .fetch_pop_i(pop), .decode_busy_i(busy), .fetch_ok_o(fetch_ok),
    .rd_ptr_o(rd_ptr), .irq_o(irq)
  );

  typedef struct {
    int          kind;  // 0 rdata, 1 irq, 2 fetch_ok
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  probe_ev;
  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;

  // monitor
  initial forever begin
    @(probe_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = (it.kind == 0) ? {16'd0, reg_rdata} :
            (it.kind == 1) ? {31'd0, irq} : {31'd0, fetch_ok};
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'(idx * 2); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_burst(input int idx, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'(idx * 2); reg_wdata = d; burst = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; burst = 1'b0;
  endtask

  task automatic pulse(input logic b, input logic p);
    @(negedge clk);
    burst = b; pop = p;
    @(negedge clk);
    burst = 1'b0; pop = 1'b0;
  endtask

  task automatic expect_at(input int kind, input logic [31:0] e, input string tag);
    #2;
    exp_q.push_back('{kind, e, tag});
    -> probe_ev;
    #1;
  endtask

  task automatic rd(input int idx, input logic [15:0] e, input string tag);
    @(negedge clk);
    reg_addr = 12'(idx * 2);
    expect_at(0, {16'd0, e}, tag);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    expect_at(1, {31'd0, e}, tag);
  endtask

  task automatic chk_ok(input logic e, input string tag);
    @(negedge clk);
    expect_at(2, {31'd0, e}, tag);
  endtask

  localparam int ST = 0, CT = 1, CL = 2, TK = 3;
  localparam int BASE = 16, ENDR = 18, HIW = 20, LOW = 22, DST = 24, WP = 26, RP = 28, BP = 30;

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_ni = 1'b1;

    // R1 reset state
    rd(ST, 16'h000C, "R1 state reset");
    rd(CT, 16'h0000, "R1 control reset");
    rd(TK, 16'h0000, "R1 token reset");
    rd(WP, 16'h0000, "R1 producer reset");
    rd(DST + 1, 16'h0000, "R1 distance hi reset");
    chk_irq(1'b0, "R1 irq reset");

    // R4 decode
    wr(TK, 16'hBEEF);
    rd(TK, 16'hBEEF, "R4 token readback");
    rd(32, 16'h0000, "R4 index 0x20 reads zero");
    rd(2047, 16'h0000, "R4 top index reads zero");
    rd(CL, 16'h0000, "R4 clear reads zero");

    // R2 / R3 halves and masking
    wr(BASE, 16'h123F);
    rd(BASE, 16'h1220, "R3 base lo masked");
    wr(BASE + 1, 16'h0001);
    rd(BASE + 1, 16'h0001, "R2 base hi written");
    rd(BASE, 16'h1220, "R2 base lo kept");
    wr(BASE, 16'h1000); wr(BASE + 1, 16'h0000);
    wr(ENDR, 16'h1040);
    wr(WP, 16'h1000); wr(RP, 16'h1000);
    wr(HIW, 16'h0047);
    rd(HIW, 16'h0047, "R3 threshold lo unmasked");

    // R5 state write ignored
    wr(ST, 16'hFFFF);
    rd(ST, 16'h000C, "R5 state write ignored");

    // R6 link off
    pulse(1'b1, 1'b0);
    rd(WP, 16'h1000, "R6 no link producer held");
    rd(DST, 16'h0000, "R6 no link distance held");

    // R6 link on, wrap; R9 overflow; R13
    wr(CT, 16'h0014);
    pulse(1'b1, 1'b0);
    rd(WP, 16'h1020, "R6 producer step");
    rd(ST, 16'h0008, "R12 not idle after burst");
    pulse(1'b1, 1'b0);
    rd(WP, 16'h1040, "R6 producer at end");
    pulse(1'b1, 1'b0);
    rd(WP, 16'h1000, "R6 producer wrapped");
    rd(DST, 16'h0060, "R6 distance grows");
    rd(ST, 16'h000D, "R9 overflow set");
    chk_irq(1'b1, "R13 overflow irq");

    // R9 sticky, R10 clear
    wr(HIW, 16'h0100);
    rd(ST, 16'h000D, "R9 overflow sticky");
    wr(CL, 16'h0001);
    rd(ST, 16'h000C, "R10 overflow cleared");
    chk_irq(1'b0, "R13 irq drops");

    // R7 fetch
    pulse(1'b1, 1'b0);
    wr(CT, 16'h0011);
    chk_ok(1'b1, "R7 fetch ok");
    pulse(1'b0, 1'b1);
    rd(RP, 16'h1020, "R7 consumer step");
    rd(DST, 16'h0060, "R7 distance shrinks");
    chk_ok(1'b0, "R7 empty blocks fetch");
    pulse(1'b0, 1'b1);
    rd(RP, 16'h1020, "R7 pop while empty ignored");

    // R8 same-cycle push and pop with producer wrap
    pulse(1'b1, 1'b0);
    rd(DST, 16'h0080, "R8 distance before");
    pulse(1'b1, 1'b1);
    rd(WP, 16'h1000, "R8 producer wrapped");
    rd(RP, 16'h1040, "R8 consumer step");
    rd(DST, 16'h0080, "R8 distance net zero");

    // R11 stop address
    wr(BP, 16'h1040);
    wr(CT, 16'h0033);
    rd(ST, 16'h0018, "R11 stop flag set");
    chk_irq(1'b1, "R13 stop irq");
    chk_ok(1'b0, "R7 stopped blocks fetch");
    pulse(1'b0, 1'b1);
    rd(RP, 16'h1040, "R7 pop while stopped ignored");
    wr(CT, 16'h0021);
    rd(ST, 16'h0008, "R11 stop flag drops");
    chk_irq(1'b0, "R13 stop irq drops");
    chk_ok(1'b1, "R7 fetch resumes");

    // R9 underflow, set wins; R10
    wr(CT, 16'h0008);
    wr(LOW, 16'h0200);
    rd(ST, 16'h000A, "R9 underflow set");
    chk_irq(1'b1, "R13 underflow irq");
    wr(CL, 16'h0002);
    rd(ST, 16'h000A, "R9 set wins over clear");
    wr(LOW, 16'h0000);
    rd(ST, 16'h000A, "R9 underflow sticky");
    wr(CL, 16'h0002);
    rd(ST, 16'h0008, "R10 underflow cleared");
    chk_irq(1'b0, "R13 underflow irq drops");

    // R12 command idle
    @(negedge clk) busy = 1'b1;
    rd(ST, 16'h0000, "R12 command busy");
    @(negedge clk) busy = 1'b0;
    rd(ST, 16'h0008, "R12 command idle");

    // R14 bus write beats burst
    wr(CT, 16'h0010);
    wr_burst(DST, 16'h031F);
    rd(DST, 16'h0300, "R14 distance write wins");
    rd(WP, 16'h1020, "R14 producer still steps");

    #20;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule